// File: doc/BRIEF.md
# Staircase Soft-Start Reference Sequencer

This block produces the digital reference code that a voltage-mode regulation loop uses as its set point while the converter starts up. After enable, the code climbs from zero to full scale in 64 equal steps. The error amplifier therefore sees a slowly rising target, the output voltage rises monotonically, and inrush current stays bounded. A digital-to-analog stage outside this block turns the code into a voltage.

The sequencer counts switching-cycle ticks, not system clock cycles. Each step lasts 32 ticks, so a complete ramp takes 2048 switching cycles. Its duration therefore scales with the switching frequency: at 250 kHz the ramp lasts about 8 ms. When the last step has run its full length, the code stays at full scale and a done flag is raised.

Dropping enable, or pulsing the fault restart input, returns the ramp to zero on the next clock edge.

Top module: `softstart_ref_seq`

## Requirements
- R1: While reset is asserted, ramp_code is 0, ref_valid is 0 and ramp_done is 0.
- R2: With enable held high and no restart, after n switching ticks ramp_code equals floor(n/32), for n below 2016.
- R3: ramp_code changes only on the clock edge that samples sw_tick high; on edges with sw_tick low, ramp_code keeps its value.
- R4: While enable is high and restart is low, ramp_code never decreases, and it increases by at most one per edge.
- R5: ramp_code reaches 63 after 2016 ticks. ramp_done rises on the edge of tick 2048. After that, ramp_code stays at 63 and ramp_done stays at 1 for any further ticks.
- R6: On the first edge with enable low, ramp_code, the tick counter, ramp_done and ref_valid all clear. Ticks that arrive while enable is low have no effect.
- R7: A restart pulse clears ramp_code, the tick counter, ramp_done and ref_valid on the next edge. The ramp then starts again from zero, and the next step comes only after a full 32 ticks.
- R8: ref_valid is 1 on the edge after any cycle in which enable is high and restart is low, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Ramp enable; low holds the ramp at zero |
| restart | input | 1 | Fault restart request; a one-cycle pulse clears the ramp |
| sw_tick | input | 1 | One-cycle pulse per switching period |
| ramp_code | output | 6 | Reference step code, 0 to 63 |
| ref_valid | output | 1 | Reference is being driven by an active ramp |
| ramp_done | output | 1 | Ramp has finished and holds full scale |

## Verification
Every result is a single register stage away from the stimulus. A tick, restart or enable change applied in one cycle therefore shows on the ports after the very next rising edge. The bench drives its inputs just after a falling edge and samples one falling edge later, so each check lands exactly one edge after its stimulus. Expected codes come from the number of ticks issued since the last clear, floor(n/32) capped at 63. Idle cycles placed between ticks confirm that nothing moves without a tick.

// File: rtl/softstart_pkg.sv
package softstart_pkg;
  localparam int unsigned SS_STEPS      = 64;
  localparam int unsigned SS_TICKS_STEP = 32;
  localparam int unsigned SS_STEP_W     = $clog2(SS_STEPS);
  localparam int unsigned SS_CYC_W      = $clog2(SS_TICKS_STEP);

  typedef logic [SS_STEP_W-1:0] ss_code_t;
endpackage

// File: rtl/softstart_tick_div.sv
module softstart_tick_div #(
  parameter int unsigned TICKS_PER_STEP = 32,
  localparam int unsigned CW = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic step_adv
);
  localparam logic [CW-1:0] CNT_LAST = CW'(TICKS_PER_STEP - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en   = clear | (run & tick);
    step_adv = ~clear & run & tick & (cnt_q == CNT_LAST);
    if (clear)                 cnt_d = '0;
    else if (cnt_q == CNT_LAST) cnt_d = '0;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7: a clear always leaves the tick counter at zero
  a_r7_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt_q == '0);
  // R3: without a tick the counter holds
  a_r3_cnt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/softstart_step_ctr.sv
module softstart_step_ctr #(
  parameter int unsigned STEPS = 64,
  localparam int unsigned SW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step_adv,
  output logic [SW-1:0] code,
  output logic          done
);
  localparam logic [SW-1:0] CODE_TOP = SW'(STEPS - 1);

  logic [SW-1:0] code_q, code_d;
  logic          done_q, done_d;
  logic          upd_en;

  always_comb begin
    upd_en = clear | step_adv;
    code_d = code_q;
    done_d = done_q;
    if (clear) begin
      code_d = '0;
      done_d = 1'b0;
    end else if (step_adv) begin
      if (code_q == CODE_TOP) done_d = 1'b1;
      else                    code_d = code_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      done_q <= 1'b0;
    end else if (upd_en) begin
      code_q <= code_d;
      done_q <= done_d;
    end
  end

  assign code = code_q;
  assign done = done_q;

  // R5: done only ever accompanies full scale
  a_r5_done_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> code_q == CODE_TOP);
  // R4: code rises by at most one and never falls unless cleared
  a_r4_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (code_q == $past(code_q)) || (code_q == $past(code_q) + 1'b1));
endmodule

// File: rtl/softstart_ref_seq.sv
module softstart_ref_seq
  import softstart_pkg::*;
#(
  parameter int unsigned STEPS          = SS_STEPS,
  parameter int unsigned TICKS_PER_STEP = SS_TICKS_STEP,
  localparam int unsigned SW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          restart,
  input  logic          sw_tick,
  output logic [SW-1:0] ramp_code,
  output logic          ref_valid,
  output logic          ramp_done
);
  logic clear;
  logic run;
  logic step_adv;
  logic done_w;
  logic valid_q, valid_d;

  always_comb begin
    clear   = ~en | restart;
    run     = ~done_w;
    valid_d = en & ~restart;
  end

  softstart_tick_div #(
    .TICKS_PER_STEP(TICKS_PER_STEP)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .run     (run),
    .tick    (sw_tick),
    .step_adv(step_adv)
  );

  softstart_step_ctr #(
    .STEPS(STEPS)
  ) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .step_adv(step_adv),
    .code    (ramp_code),
    .done    (done_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign ref_valid = valid_q;
  assign ramp_done = done_w;

  // R6: dropping enable clears all outputs on the next edge
  a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (ramp_code == '0) && !ramp_done && !ref_valid);
  // R3: outputs move only on ticks while running
  a_r3_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart && !sw_tick) |=> $stable(ramp_code) && $stable(ramp_done));
  // R8: valid follows an enabled, non-restarted cycle
  a_r8_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart) |=> ref_valid);
endmodule

// File: tb/test_softstart_ref_seq.sv
`timescale 1ns/1ps
module test_softstart_ref_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic       restart;
  logic       sw_tick;
  logic [5:0] ramp_code;
  logic       ref_valid;
  logic       ramp_done;

  int checks = 0;
  int errors = 0;
  int wd     = 0;

  always #4 clk = ~clk;

  softstart_ref_seq i_softstart_ref_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .restart  (restart),
    .sw_tick  (sw_tick),
    .ramp_code(ramp_code),
    .ref_valid(ref_valid),
    .ramp_done(ramp_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive for one cycle from a falling edge, return at next falling edge
  task automatic cyc(input logic tk, input logic rs);
    sw_tick = tk;
    restart = rs;
    @(negedge clk);
    sw_tick = 1'b0;
    restart = 1'b0;
  endtask

  function automatic int exp_code(input int n);
    return (n / 32 > 63) ? 63 : n / 32;
  endfunction

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int prev;
    rst_n = 1'b0; en = 1'b0; restart = 1'b0; sw_tick = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 code", ramp_code, 0);
    chk("R1 valid", ref_valid, 0);
    chk("R1 done", ramp_done, 0);
    rst_n = 1'b1;
    en = 1'b1;
    cyc(1'b0, 1'b0);
    chk("R8 valid after enable", ref_valid, 1);
    chk("R2 code at start", ramp_code, 0);

    // full sweep, a tick every cycle
    prev = 0;
    for (int n = 1; n <= 2100; n++) begin
      cyc(1'b1, 1'b0);
      if (n < 2016) chk("R2 code", ramp_code, exp_code(n));
      else          chk("R5 code", ramp_code, 63);
      chk("R5 done", ramp_done, (n >= 2048) ? 1 : 0);
      if (ramp_code < prev) chk("R4 monotonic", ramp_code, prev);
      prev = ramp_code;
      chk("R8 valid held", ref_valid, 1);
    end

    // disable clears, ticks ignored while disabled
    en = 1'b0;
    cyc(1'b0, 1'b0);
    chk("R6 code", ramp_code, 0);
    chk("R6 done", ramp_done, 0);
    chk("R6 valid", ref_valid, 0);
    for (int k = 0; k < 40; k++) cyc(1'b1, 1'b0);
    chk("R6 ticks ignored", ramp_code, 0);

    // gapped ticks: idle cycles must not move the code
    en = 1'b1;
    cyc(1'b0, 1'b0);
    for (int n = 1; n <= 200; n++) begin
      cyc(1'b1, 1'b0);
      chk("R2 gapped code", ramp_code, exp_code(n));
      for (int g = 0; g < 2; g++) begin
        cyc(1'b0, 1'b0);
        chk("R3 idle hold", ramp_code, exp_code(n));
      end
    end

    // disabled-sweep ticks were ignored: 40 ticks did not pre-load counter (R6)
    // restart mid-ramp, with a tick in the same cycle
    cyc(1'b1, 1'b1);
    chk("R7 code cleared", ramp_code, 0);
    chk("R7 valid drop", ref_valid, 0);
    chk("R7 done", ramp_done, 0);
    for (int n = 1; n <= 31; n++) cyc(1'b1, 1'b0);
    chk("R7 no early step", ramp_code, 0);
    chk("R8 valid back", ref_valid, 1);
    cyc(1'b1, 1'b0);
    chk("R7 step after 32", ramp_code, 1);

    // restart from done state
    for (int n = 0; n < 2100; n++) cyc(1'b1, 1'b0);
    chk("R5 done again", ramp_done, 1);
    cyc(1'b0, 1'b1);
    chk("R7 done cleared", ramp_done, 0);
    chk("R7 code zero", ramp_code, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule